// File: doc/BRIEF.md
# Clock Synthesizer Bring-Up Sequencer

This block brings an external two-stage clock synthesizer into a running, locked state after power-up. It walks a small built-in table of configuration writes. Each register is read back at once and compared against the value just written. After the whole table has been checked, the block issues the device's update command so that the staged values take effect.

It then runs the VCO calibration handshake. A read-modify-write sets the calibrate bit, followed by an update. The block polls the calibration busy flag at a paced rate until the flag clears. A second read-modify-write then clears the calibrate bit, followed by another update. Without that final clear, the second PLL never locks. Last, the block reads the reference/lock status register and reports whether the second PLL locked. The holdover flag of the first PLL is reported as well.

All device traffic goes through a single-outstanding request port toward an SPI master, which sits outside this block. Each request is presented as an address, write data and a read/write flag under a valid/ready handshake. Each request is closed by a response strobe that carries the read data.

Top module: `clksynth_bringup_seq`

## Requirements
- R1: After `start_i` in idle, the table writes go out in this order: 0x010←0x7C, 0x01A←0xE7, 0x0F0←0x0A, 0x0F2←0x03. The 0x01A value has bits 3 and 4 clear, which powers down both reference input receivers.
- R2: Each table write is followed directly by a read of the same address, before the next table write.
- R3: If a readback differs from the value written, `error_o` rises and stays high. No further request is made and `done_o` never pulses.
- R4: After the last good readback, the block writes 0x01 to the update register 0x234.
- R5: Calibration start is a read of 0x0F3, then a write of that value with bit 1 set and every other bit unchanged, then an update write (0x234←0x01).
- R6: The busy flag is bit 0 of 0x22D. It is polled while it reads 1, and polling stops at the first read of 0. Between a poll's response and the next poll's request there are at least `SETTLE_CYC` clock cycles.
- R7: If `poll_limit_i` consecutive polls read busy, `timeout_o` and `error_o` assert and no further request is made.
- R8: Once busy reads 0, the block reads 0x0F3 and writes it back with bit 1 clear and all other bits unchanged. It then issues an update write.
- R9: The block then reads 0x22C, and `locked_o` takes bit 1 of that read. If the bit is 1, `done_o` pulses for exactly one cycle. Otherwise `error_o` asserts.
- R10: `holdover_o` follows bit 3 of the most recent 0x22D read. A new start clears it.
- R11: A request holds `req_valid_o`, address, data and direction steady until `req_ready_i`. Only one request is outstanding, and it closes on `rsp_valid_i`.
- R12: After reset all outputs are 0 and no request is made. A `start_i` while a bring-up is in progress is ignored. A `start_i` in the error state restarts the sequence and clears the status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bring-up (idle or error state only) |
| poll_limit_i | input | POLL_W | Maximum number of busy polls, at least 1 |
| req_valid_o | output | 1 | Register request valid |
| req_ready_i | input | 1 | Request accepted by the bus master |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 12 | Device register address |
| req_wdata_o | output | 8 | Write data |
| rsp_valid_i | input | 1 | Request completed |
| rsp_rdata_i | input | 8 | Read data, valid with rsp_valid_i |
| done_o | output | 1 | One-cycle pulse on successful bring-up |
| error_o | output | 1 | Sequence stopped on a failure |
| locked_o | output | 1 | Second PLL reported locked |
| holdover_o | output | 1 | First PLL reported in holdover |
| timeout_o | output | 1 | Calibration busy flag never cleared |

## Verification
The assertions rely on the bus side behaving as a well-formed single-outstanding master. It must raise `rsp_valid_i` only after a request has been accepted, and never twice for one request. `poll_limit_i` must also stay at a non-zero value for the whole run. The bench models the device so that it keeps to these rules. It drops ready while a response is pending and returns exactly one response after a random delay of one to three cycles. It draws every poll limit from 1 upward. Random cases vary the initial calibration-control value, busy length, limit, holdover flag, readback corruption and lock failure.

// File: rtl/csbu_pkg.sv
package csbu_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] REG_CAL_CTRL = 12'h0F3;
    localparam logic [ADDR_W-1:0] REG_REF_STAT = 12'h22C;
    localparam logic [ADDR_W-1:0] REG_PLL_STAT = 12'h22D;
    localparam logic [ADDR_W-1:0] REG_UPDATE   = 12'h234;
    localparam logic [DATA_W-1:0] UPDATE_VAL   = 8'h01;

    localparam int CAL_BIT  = 1;
    localparam int LOCK_BIT = 1;
    localparam int BUSY_BIT = 0;
    localparam int HOLD_BIT = 3;

    localparam int CFG_DEPTH = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_WRITE, S_READBACK, S_UPDATE, S_CAL_START,
        S_CAL_POLL, S_CAL_STOP, S_CHECK_LOCK, S_DONE, S_ERROR
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_CFG, PH_CAL_ON, PH_CAL_OFF
    } upd_phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic bus_cmd_t cfg_entry(input int idx);
        bus_cmd_t c;
        c.wr = 1'b1;
        case (idx)
            0:       begin c.addr = 12'h010; c.data = 8'h7C; end
            1:       begin c.addr = 12'h01A; c.data = 8'hE7; end
            2:       begin c.addr = 12'h0F0; c.data = 8'h0A; end
            3:       begin c.addr = 12'h0F2; c.data = 8'h03; end
            default: begin c.addr = '0;      c.data = '0;    end
        endcase
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cal_mask();
        return DATA_W'(1) << CAL_BIT;
    endfunction

endpackage

// File: rtl/csbu_cfg_rom.sv
module csbu_cfg_rom
    import csbu_pkg::*;
#(
    parameter int DEPTH = CFG_DEPTH,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output bus_cmd_t         entry
);
    bus_cmd_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = cfg_entry(g);
    end

    assign entry = rom[idx];
endmodule

// File: rtl/csbu_bus_xact.sv
module csbu_bus_xact
    import csbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  bus_cmd_t          cmd,
    output logic              busy,
    output logic              fin,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i
);
    typedef enum logic [1:0] {X_IDLE, X_REQ, X_WAIT} xact_state_e;

    xact_state_e xs;
    bus_cmd_t    cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xs    <= X_IDLE;
            cmd_q <= '0;
        end else begin
            case (xs)
                X_IDLE: if (go) begin
                    cmd_q <= cmd;
                    xs    <= X_REQ;
                end
                X_REQ:  if (req_ready_i) xs <= X_WAIT;
                X_WAIT: if (rsp_valid_i) xs <= X_IDLE;
                default: xs <= X_IDLE;
            endcase
        end
    end

    assign busy        = (xs != X_IDLE);
    assign fin         = (xs == X_WAIT) && rsp_valid_i;
    assign req_valid_o = (xs == X_REQ);
    assign req_write_o = cmd_q.wr;
    assign req_addr_o  = cmd_q.addr;
    assign req_wdata_o = cmd_q.data;
endmodule

// File: rtl/csbu_poll_pacer.sv
module csbu_poll_pacer #(
    parameter int SETTLE_CYC = 8,
    parameter int POLL_W     = 16,
    localparam int SW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              clear,
    input  logic              count,
    input  logic [POLL_W-1:0] limit,
    output logic              elapsed,
    output logic              last_poll
);
    logic [SW-1:0]     settle_q;
    logic [POLL_W-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_q <= '0;
            busy_q   <= '0;
        end else begin
            if (arm)                 settle_q <= SW'(SETTLE_CYC);
            else if (settle_q != '0) settle_q <= settle_q - 1'b1;
            if (clear)               busy_q <= '0;
            else if (count)          busy_q <= busy_q + 1'b1;
        end
    end

    assign elapsed   = (settle_q == '0);
    assign last_poll = ({1'b0, busy_q} + (POLL_W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/clksynth_bringup_seq.sv
module clksynth_bringup_seq
    import csbu_pkg::*;
#(
    parameter int CFG_LEN    = CFG_DEPTH,
    parameter int SETTLE_CYC = 8,
    parameter int POLL_W     = 16,
    localparam int IDX_W = (CFG_LEN > 1) ? $clog2(CFG_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [POLL_W-1:0] poll_limit_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output logic              done_o,
    output logic              error_o,
    output logic              locked_o,
    output logic              holdover_o,
    output logic              timeout_o
);
    seq_state_e        state;
    upd_phase_e        phase;
    logic [IDX_W-1:0]  idx;
    logic              pend, rmw_wr;
    logic [DATA_W-1:0] rmw_val;
    logic              done_q, locked_q, hold_q, tout_q;

    bus_cmd_t rom_entry, cmd;
    logic     go, xbusy, fin, need_xact;
    logic     settle_ok, last_poll;
    logic     pace_arm, pace_clear, pace_count;

    csbu_cfg_rom #(.DEPTH(CFG_LEN)) u_rom (.idx(idx), .entry(rom_entry));

    csbu_bus_xact u_xact (
        .clk(clk), .rst(rst), .go(go), .cmd(cmd), .busy(xbusy), .fin(fin),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_write_o(req_write_o), .req_addr_o(req_addr_o),
        .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i)
    );

    csbu_poll_pacer #(.SETTLE_CYC(SETTLE_CYC), .POLL_W(POLL_W)) u_pacer (
        .clk(clk), .rst(rst), .arm(pace_arm), .clear(pace_clear),
        .count(pace_count), .limit(poll_limit_i),
        .elapsed(settle_ok), .last_poll(last_poll)
    );

    // Command selection for the current step
    always_comb begin
        cmd       = '0;
        need_xact = 1'b1;
        case (state)
            S_WRITE:      cmd = rom_entry;
            S_READBACK:   cmd = '{wr: 1'b0, addr: rom_entry.addr, data: '0};
            S_UPDATE:     cmd = '{wr: 1'b1, addr: REG_UPDATE, data: UPDATE_VAL};
            S_CAL_START:  cmd = '{wr: rmw_wr, addr: REG_CAL_CTRL,
                                  data: rmw_wr ? (rmw_val | cal_mask()) : '0};
            S_CAL_STOP:   cmd = '{wr: rmw_wr, addr: REG_CAL_CTRL,
                                  data: rmw_wr ? (rmw_val & ~cal_mask()) : '0};
            S_CAL_POLL: begin
                cmd       = '{wr: 1'b0, addr: REG_PLL_STAT, data: '0};
                need_xact = settle_ok;
            end
            S_CHECK_LOCK: cmd = '{wr: 1'b0, addr: REG_REF_STAT, data: '0};
            default:      need_xact = 1'b0;
        endcase
        go = need_xact && !pend && !xbusy;
    end

    always_comb begin
        pace_clear = fin && (state == S_UPDATE) && (phase == PH_CAL_ON);
        pace_count = fin && (state == S_CAL_POLL) && rsp_rdata_i[BUSY_BIT];
        pace_arm   = pace_clear || pace_count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            phase    <= PH_CFG;
            idx      <= '0;
            pend     <= 1'b0;
            rmw_wr   <= 1'b0;
            rmw_val  <= '0;
            done_q   <= 1'b0;
            locked_q <= 1'b0;
            hold_q   <= 1'b0;
            tout_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go)  pend <= 1'b1;
            if (fin) pend <= 1'b0;
            case (state)
                S_IDLE, S_ERROR: if (start_i) begin
                    state    <= S_WRITE;
                    idx      <= '0;
                    locked_q <= 1'b0;
                    hold_q   <= 1'b0;
                    tout_q   <= 1'b0;
                end
                S_WRITE: if (fin) state <= S_READBACK;
                S_READBACK: if (fin) begin
                    if (rsp_rdata_i != rom_entry.data) begin
                        state <= S_ERROR;
                    end else if (idx == IDX_W'(CFG_LEN - 1)) begin
                        state <= S_UPDATE;
                        phase <= PH_CFG;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_WRITE;
                    end
                end
                S_UPDATE: if (fin) begin
                    rmw_wr <= 1'b0;
                    case (phase)
                        PH_CFG:    state <= S_CAL_START;
                        PH_CAL_ON: state <= S_CAL_POLL;
                        default:   state <= S_CHECK_LOCK;
                    endcase
                end
                S_CAL_START, S_CAL_STOP: if (fin) begin
                    if (!rmw_wr) begin
                        rmw_val <= rsp_rdata_i;
                        rmw_wr  <= 1'b1;
                    end else begin
                        rmw_wr <= 1'b0;
                        state  <= S_UPDATE;
                        phase  <= (state == S_CAL_START) ? PH_CAL_ON : PH_CAL_OFF;
                    end
                end
                S_CAL_POLL: if (fin) begin
                    hold_q <= rsp_rdata_i[HOLD_BIT];
                    if (!rsp_rdata_i[BUSY_BIT]) begin
                        state  <= S_CAL_STOP;
                        rmw_wr <= 1'b0;
                    end else if (last_poll) begin
                        tout_q <= 1'b1;
                        state  <= S_ERROR;
                    end
                end
                S_CHECK_LOCK: if (fin) begin
                    locked_q <= rsp_rdata_i[LOCK_BIT];
                    if (rsp_rdata_i[LOCK_BIT]) begin
                        state  <= S_DONE;
                        done_q <= 1'b1;
                    end else begin
                        state <= S_ERROR;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done_o     = done_q;
    assign error_o    = (state == S_ERROR);
    assign locked_o   = locked_q;
    assign holdover_o = hold_q;
    assign timeout_o  = tout_q;
endmodule

// File: rtl/csbu_checker.sv
module csbu_checker
    import csbu_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic              req_write_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [DATA_W-1:0] req_wdata_o,
    input logic              rsp_valid_i,
    input logic              done_o,
    input logic              error_o,
    input logic              locked_o,
    input logic              holdover_o,
    input logic              timeout_o
);
    logic [15:0] gap_q;
    logic        seen_q, rd_stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= '0;
            seen_q    <= 1'b0;
            rd_stat_q <= 1'b0;
        end else begin
            if (req_valid_o && req_ready_i) begin
                rd_stat_q <= !req_write_o && (req_addr_o == REG_PLL_STAT);
                if (req_write_o) seen_q <= 1'b0;
            end
            if (rsp_valid_i && rd_stat_q) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_done_locked: assert property (@(posedge clk) disable iff (rst)
        done_o |-> locked_o && !error_o);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_addr_o)
            && $stable(req_wdata_o) && $stable(req_write_o));

    a_r7_timeout_err: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> error_o);

    a_r3_quiet_err: assert property (@(posedge clk) disable iff (rst)
        error_o |-> !req_valid_o);

    a_r6_settle: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_write_o && (req_addr_o == REG_PLL_STAT) && seen_q)
            |-> (gap_q >= 16'(SETTLE_CYC)));

    a_r10_hold_src: assert property (@(posedge clk) disable iff (rst)
        !$stable(holdover_o) |-> $past(rsp_valid_i) || $past(start_i));
endmodule

bind clksynth_bringup_seq csbu_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/tb_clksynth_bringup_seq.sv
module tb_clksynth_bringup_seq;
    localparam int SETTLE = 8;
    localparam int PW     = 16;
    localparam int NCFG   = 4;
    localparam logic [11:0] A_CAL = 12'h0F3, A_REF = 12'h22C,
                            A_PLL = 12'h22D, A_UPD = 12'h234;

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
    logic [PW-1:0] poll_limit_i = 16'd4;
    logic req_valid_o, req_ready_i, req_write_o, rsp_valid_i;
    logic [11:0] req_addr_o;
    logic [7:0] req_wdata_o, rsp_rdata_i;
    logic done_o, error_o, locked_o, holdover_o, timeout_o;

    always #10 clk = ~clk;

    clksynth_bringup_seq #(.SETTLE_CYC(SETTLE), .POLL_W(PW)) dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // device model state
    logic [7:0] sh [int];
    int  busy_left, hold_cfg, corrupt_addr;
    bit  lock_fail, cal_on, cal_fin, stopped;
    bit  dpend, dstat;
    int  dlat, last_rsp, min_gap, r11_bad, done_cnt;
    bit  have_rsp;
    logic [7:0] dval;
    bit   prev_wait;
    logic [11:0] prev_addr;
    logic [7:0] prev_data;
    logic prev_wr;

    int  op_wr[$], op_addr[$], op_data[$];
    int  ex_wr[$], ex_addr[$], ex_data[$];
    string ex_tag[$];

    function automatic logic [7:0] tb_cfg_addr_lo(input int i);
        case (i) 0: return 8'h10; 1: return 8'h1A; 2: return 8'hF0; default: return 8'hF2; endcase
    endfunction
    function automatic logic [7:0] tb_cfg_data(input int i);
        case (i) 0: return 8'h7C; 1: return 8'hE7; 2: return 8'h0A; default: return 8'h03; endcase
    endfunction

    initial begin
        req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_rdata_i = '0; dpend = 0;
        forever begin
            @(negedge clk);
            rsp_valid_i = 1'b0;
            if (prev_wait && !(req_valid_o && req_addr_o == prev_addr &&
                req_wdata_o == prev_data && req_write_o == prev_wr)) r11_bad++;
            prev_wait = 0;
            if (rst) begin
                dpend = 0; req_ready_i = 1'b0;
            end else if (dpend) begin
                req_ready_i = 1'b0;
                if (dlat == 0) begin
                    rsp_valid_i = 1'b1; rsp_rdata_i = dval; dpend = 0;
                    if (dstat) begin last_rsp = cyc; have_rsp = 1; end
                end else dlat--;
            end else begin
                req_ready_i = ($urandom_range(0, 2) != 0);
                if (req_valid_o && !req_ready_i) begin
                    prev_wait = 1; prev_addr = req_addr_o;
                    prev_data = req_wdata_o; prev_wr = req_write_o;
                end
                if (req_valid_o && req_ready_i) begin
                    dpend = 1; dlat = $urandom_range(0, 2);
                    dstat = !req_write_o && req_addr_o == A_PLL;
                    if (req_write_o) begin
                        dval = req_wdata_o;
                        if (req_addr_o == A_UPD && req_wdata_o == 8'h01) begin
                            have_rsp = 0;
                            if (sh[A_CAL][1] && !cal_on) cal_on = 1;
                            else if (!sh[A_CAL][1] && cal_fin) stopped = 1;
                        end else sh[int'(req_addr_o)] = req_wdata_o;
                    end else begin
                        if (req_addr_o == A_PLL) begin
                            if (dstat && have_rsp && (cyc - last_rsp) < min_gap)
                                min_gap = cyc - last_rsp;
                            dval = 8'(hold_cfg << 3);
                            if (cal_on && busy_left > 0) begin dval[0] = 1'b1; busy_left--; end
                            else if (cal_on) cal_fin = 1;
                        end else if (req_addr_o == A_REF) begin
                            dval = (stopped && !lock_fail) ? 8'hA2 : 8'hA0;
                        end else begin
                            dval = sh.exists(int'(req_addr_o)) ? sh[int'(req_addr_o)] : 8'h00;
                            if (int'(req_addr_o) == corrupt_addr) dval = dval ^ 8'h10;
                        end
                    end
                    op_wr.push_back(req_write_o); op_addr.push_back(req_addr_o);
                    op_data.push_back(dval);
                end
            end
        end
    end

    always @(negedge clk) if (done_o) done_cnt++;

    task automatic push(input int w, input int a, input int d, input string t);
        ex_wr.push_back(w); ex_addr.push_back(a); ex_data.push_back(d); ex_tag.push_back(t);
    endtask

    task automatic build(input int v, input int busy, input int hold, input int lim,
                         input int cidx, input bit lf);
        int vv;
        for (int i = 0; i < NCFG; i++) begin
            push(1, tb_cfg_addr_lo(i), tb_cfg_data(i), "R1");
            if (cidx == i) begin push(0, tb_cfg_addr_lo(i), tb_cfg_data(i) ^ 8'h10, "R3"); return; end
            push(0, tb_cfg_addr_lo(i), tb_cfg_data(i), "R2");
        end
        push(1, A_UPD, 1, "R4");
        push(0, A_CAL, v, "R5"); vv = v | 2; push(1, A_CAL, vv, "R5"); push(1, A_UPD, 1, "R5");
        for (int k = 0; k < ((busy >= lim) ? lim : busy + 1); k++)
            push(0, A_PLL, (hold << 3) | ((k < busy) ? 1 : 0), "R6");
        if (busy >= lim) return;
        push(0, A_CAL, vv, "R8"); push(1, A_CAL, vv & 8'hFD, "R8"); push(1, A_UPD, 1, "R8");
        push(0, A_REF, lf ? 8'hA0 : 8'hA2, "R9");
    endtask

    task automatic run_case(input int v, input int busy, input int hold, input int lim,
                            input int cidx, input bit lf, input bit restart_mid);
        bit ok, tmo;
        int n, wait_c;
        sh.delete(); sh[A_CAL] = 8'(v);
        busy_left = busy; hold_cfg = hold; lock_fail = lf;
        corrupt_addr = (cidx >= 0) ? int'(tb_cfg_addr_lo(cidx)) : -1;
        cal_on = 0; cal_fin = 0; stopped = 0; have_rsp = 0;
        min_gap = 1 << 30; r11_bad = 0; done_cnt = 0;
        op_wr.delete(); op_addr.delete(); op_data.delete();
        ex_wr.delete(); ex_addr.delete(); ex_data.delete(); ex_tag.delete();
        build(v, busy, hold, lim, cidx, lf);
        @(negedge clk); poll_limit_i = PW'(lim); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (restart_mid) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R12: must be ignored
        end
        wait_c = 0;
        while (!(error_o || done_cnt > 0) && wait_c < 5000) begin @(negedge clk); wait_c++; end
        check(wait_c < 5000, "R12", "run finished", wait_c, 0);
        repeat (20) @(negedge clk);
        ok  = (cidx < 0) && (busy < lim) && !lf;
        tmo = (cidx < 0) && (busy >= lim);
        n = ex_wr.size();
        check(op_wr.size() == n, "R11", "request count", op_wr.size(), n);
        for (int i = 0; i < n && i < op_wr.size(); i++)
            check(op_wr[i] == ex_wr[i] && op_addr[i] == ex_addr[i] && op_data[i] == ex_data[i],
                  ex_tag[i], $sformatf("op %0d wr%0d addr %0h data", i, op_wr[i], op_addr[i]),
                  op_data[i], ex_data[i]);
        check(done_cnt == (ok ? 1 : 0), ok ? "R9" : "R3", "done pulses", done_cnt, ok ? 1 : 0);
        check(error_o == !ok, "R3", "error_o", error_o, !ok);
        check(timeout_o == tmo, "R7", "timeout_o", timeout_o, tmo);
        check(locked_o == ok, "R9", "locked_o", locked_o, ok);
        check(holdover_o == ((cidx < 0) ? hold : 0), "R10", "holdover_o", holdover_o,
              (cidx < 0) ? hold : 0);
        if (cidx < 0) check(min_gap >= SETTLE, "R6", "poll spacing", min_gap, SETTLE);
        check(r11_bad == 0, "R11", "held request changed", r11_bad, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_C10C);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done_o && !error_o && !locked_o && !holdover_o && !timeout_o,
              "R12", "status after reset", {done_o, error_o, locked_o, holdover_o, timeout_o}, 0);
        check(!req_valid_o, "R12", "no request after reset", req_valid_o, 0);
        run_case(8'h00, 2, 0, 5, -1, 0, 0);   // nominal
        run_case(8'hFF, 0, 1, 3, -1, 0, 0);   // R5 R8: other bits kept, busy clears at once
        run_case(8'h55, 3, 0, 4, -1, 0, 0);   // R7 boundary: limit-1 busy polls
        run_case(8'h10, 4, 1, 4, -1, 0, 0);   // R7: busy equals limit -> timeout
        run_case(8'h00, 1, 0, 5, 3, 0, 0);    // R3: last readback corrupt
        run_case(8'h20, 1, 1, 5, -1, 1, 0);   // R9: lock not reported
        run_case(8'h81, 3, 0, 6, -1, 0, 1);   // R12: start during run ignored
        for (int r = 0; r < 8; r++) begin
            int lim, cidx;
            lim  = $urandom_range(1, 6);
            cidx = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NCFG - 1) : -1;
            run_case($urandom_range(0, 255), $urandom_range(0, 6), $urandom_range(0, 1),
                     lim, cidx, ($urandom_range(0, 5) == 0), 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R12 watchdog expired: actual 0x%0h expected 0x%0h", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule